// File: doc/BRIEF.md
# Reloadable Interval Timer Pair

This block holds two independent down-counting interval timers behind a small register bus. Each timer has a live count register and a reload register. The reload register carries the reload value in its upper bits. Its two lowest bits are control bits: one starts the timer and the other picks single-shot operation instead of free-running operation.

When a running timer's count reaches zero, the timer raises a sticky flag in a shared status register. A periodic timer then restarts from its reload value. A single-shot timer stops at zero. Software clears a flag by writing a one to its status bit. Each flag drives its own level interrupt line, so two consumers can service the timers separately.

Bus accesses are single-cycle. A write is taken at the clock edge while `bus_wen` is high. Read data is combinational from `bus_addr`. Byte offsets: timer 0 count at 0x04, timer 0 reload at 0x08, timer 1 count at 0x0C, timer 1 reload at 0x10, status at 0x20.

Top module: `intv_timer_pair`

## Requirements
- R1: After reset, every register reads zero and both interrupt lines are low.
- R2: A write to a reload register (0x08 or 0x10) stores the whole written word, which reads back unchanged. At the same clock edge the count is loaded with the written word with bits 1:0 forced to zero.
- R3: Reload bit 0 is the run bit. While it is 0 the count holds its value.
- R4: While the run bit is 1, the count decreases by one per clock. A write to a count register (0x04 or 0x0C) sets the count to the written word. A reload-register write takes priority over counting in that cycle.
- R5: In periodic mode (reload bit 1 = 0), a running timer whose count is zero sets its flag at the next edge and reloads the count with reload bits 31:2 and bits 1:0 zero. After a reload write of value V, the flag appears V+1 clocks later, and the count reads V in that same cycle.
- R6: In single-shot mode (reload bit 1 = 1), a running timer at zero sets its flag and clears the run bit in the reload register at the next edge. The count then stays at zero and the flag is not set again.
- R7: Status bit 0 is the timer 0 flag and bit 1 is the timer 1 flag. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged. If an expiry and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: Status bits above bit 1 read zero, and offsets that map to no register read zero.
- R9: `irq_o[i]` equals timer i's flag, and activity of one timer never changes the other timer's count, reload or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wen | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| irq_o | output | 2 | Level interrupt per timer |

## Verification
The bench builds the block with its default 32-bit counter width. It programs only small reload values, so every expiry arrives within a few dozen clocks. This keeps a sweep of every reload value from 0 to 28 in steps of four affordable on both timers in periodic mode, and a set of single-shot runs, inside one short run. In each case the measured period is compared with the arithmetic value of reload plus one. The same-cycle clear-versus-expiry corner is reached by running a timer with a reload of zero, which makes it expire on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_TMR  = 2;
    localparam int ADDR_W   = 6;
    localparam int BIT_RUN  = 0;
    localparam int BIT_ONCE = 1;

    localparam logic [ADDR_W-1:0] OFS_CNT0 = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD0 = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT1 = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RLD1 = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h20;

    function automatic logic [ADDR_W-1:0] cnt_ofs(input int idx);
        return (idx == 0) ? OFS_CNT0 : OFS_CNT1;
    endfunction

    function automatic logic [ADDR_W-1:0] rld_ofs(input int idx);
        return (idx == 0) ? OFS_RLD0 : OFS_RLD1;
    endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             fire_o
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-2){1'b1}}, 2'b00};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
    } chan_t;

    chan_t st_d, st_q;
    logic  fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (rld_we) begin
            st_d.rld = wdata;
            st_d.cnt = wdata & LOW_MASK;
        end else if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (st_q.rld[BIT_RUN]) begin
            if (st_q.cnt == '0) begin
                fire = 1'b1;
                if (st_q.rld[BIT_ONCE]) begin
                    st_d.rld[BIT_RUN] = 1'b0;
                end else begin
                    st_d.cnt = st_q.rld & LOW_MASK;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign rld_o  = st_q.rld;
    assign fire_o = fire;
endmodule

// File: rtl/tmr_stat.sv
module tmr_stat #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/intv_timer_pair.sv
module intv_timer_pair #(
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_wen,
    input  logic [CNT_W-1:0]           bus_wdata,
    output logic [CNT_W-1:0]           bus_rdata,
    output logic [tmr_pkg::NUM_TMR-1:0] irq_o
);
    import tmr_pkg::*;

    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_TMR-1:0][CNT_W-1:0] rld_vec;
    logic [NUM_TMR-1:0]            fire_vec;
    logic [NUM_TMR-1:0]            clr_vec;
    logic [NUM_TMR-1:0]            flag_vec;
    logic                          stat_we;

    assign stat_we = bus_wen && (bus_addr == OFS_STAT);
    assign clr_vec = stat_we ? bus_wdata[NUM_TMR-1:0] : '0;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_we (bus_wen && (bus_addr == cnt_ofs(i))),
            .rld_we (bus_wen && (bus_addr == rld_ofs(i))),
            .wdata  (bus_wdata),
            .cnt_o  (cnt_vec[i]),
            .rld_o  (rld_vec[i]),
            .fire_o (fire_vec[i])
        );
    end

    tmr_stat #(.N(NUM_TMR)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire_vec),
        .clr_i  (clr_vec),
        .flag_o (flag_vec)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT0: bus_rdata = cnt_vec[0];
            OFS_RLD0: bus_rdata = rld_vec[0];
            OFS_CNT1: bus_rdata = cnt_vec[1];
            OFS_RLD1: bus_rdata = rld_vec[1];
            OFS_STAT: bus_rdata = {{(CNT_W-NUM_TMR){1'b0}}, flag_vec};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = flag_vec;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 32
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [tmr_pkg::ADDR_W-1:0]              bus_addr,
    input logic                                    bus_wen,
    input logic [CNT_W-1:0]                        bus_wdata,
    input logic [CNT_W-1:0]                        bus_rdata,
    input logic [tmr_pkg::NUM_TMR-1:0]             irq_o,
    input logic [tmr_pkg::NUM_TMR-1:0][CNT_W-1:0]  cnt_vec,
    input logic [tmr_pkg::NUM_TMR-1:0][CNT_W-1:0]  rld_vec
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-2){1'b1}}, 2'b00};

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STAT) |-> (bus_rdata[CNT_W-1:NUM_TMR] == '0));

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        assert_reload_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wen && bus_addr == rld_ofs(g)) |=>
            (cnt_vec[g] == ($past(bus_wdata) & LOW_MASK)));

        assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wen && !rld_vec[g][BIT_RUN]) |=> $stable(cnt_vec[g]));

        assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[g]) |-> $past(rld_vec[g][BIT_RUN] && cnt_vec[g] == '0));

        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[g] && !(bus_wen && bus_addr == OFS_STAT && bus_wdata[g])) |=> irq_o[g]);

        assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wen && rld_vec[g][BIT_RUN] && rld_vec[g][BIT_ONCE] && cnt_vec[g] == '0)
            |=> !rld_vec[g][BIT_RUN]);
    end
endmodule

bind intv_timer_pair tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cnt_vec   (cnt_vec),
    .rld_vec   (rld_vec)
);

// File: tb/sim_intv_timer_pair.sv
`timescale 1ns/1ps
module sim_intv_timer_pair;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic         bus_wen = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [1:0]   irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intv_timer_pair #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [5:0] cofs(input int t);
        return (t == 0) ? 6'h04 : 6'h0C;
    endfunction

    function automatic logic [5:0] rofs(input int t);
        return (t == 0) ? 6'h08 : 6'h10;
    endfunction

    task automatic wait_irq(input int t, output int n);
        n = 0;
        while (!irq_o[t] && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        foreach (v[i]) begin end
        rd(6'h04, v); chk(v == 0, "R1 cnt0", v, 0);
        rd(6'h08, v); chk(v == 0, "R1 rld0", v, 0);
        rd(6'h0C, v); chk(v == 0, "R1 cnt1", v, 0);
        rd(6'h10, v); chk(v == 0, "R1 rld1", v, 0);
        rd(6'h20, v); chk(v == 0, "R1 stat", v, 0);
        chk(irq_o == 0, "R1 irq", W'(irq_o), 0);

        // R2: reload write with run bit clear, low bits masked into count
        wr(6'h08, 32'h0000_0013 & ~32'h1);
        rd(6'h08, v); chk(v == 32'h12, "R2 rld0 readback", v, 32'h12);
        rd(6'h04, v); chk(v == 32'h10, "R2 cnt0 masked", v, 32'h10);
        // R3: stopped timer holds
        repeat (10) @(negedge clk);
        rd(6'h04, v); chk(v == 32'h10, "R3 cnt0 held", v, 32'h10);
        // R4: direct count write, then counting down
        wr(6'h0C, 32'h7);
        rd(6'h0C, v); chk(v == 32'h7, "R4 cnt1 direct", v, 32'h7);
        wr(6'h10, 32'h0000_0101);
        repeat (5) @(negedge clk);
        rd(6'h0C, v); chk(v == 32'hFB, "R4 cnt1 down by 5", v, 32'hFB);
        wr(6'h10, 32'h0);
        wr(6'h20, 32'h3);

        // R5 / R9: periodic sweep on both timers
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r <= 28; r += 4) begin
                wr(6'h08, 0); wr(6'h10, 0); wr(6'h20, 32'h3);
                wr(rofs(t), W'(r) | 32'h1);
                wait_irq(t, n);
                chk(n == r + 1, "R5 period", W'(n), W'(r + 1));
                rd(cofs(t), v); chk(v == W'(r), "R5 reloaded count", v, W'(r));
                chk(irq_o[1-t] == 1'b0, "R9 other irq quiet", W'(irq_o), W'(1 << t));
                wait_irq(t, n);
                rd(cofs(1-t), v); chk(v == 0, "R9 other count untouched", v, 0);
            end
        end
        wr(6'h08, 0); wr(6'h10, 0); wr(6'h20, 32'h3);

        // R6: single-shot
        for (int t = 0; t < 2; t++) begin
            wr(rofs(t), 32'h0000_000B);
            wait_irq(t, n);
            chk(n == 9, "R6 one-shot delay", W'(n), 9);
            rd(rofs(t), v); chk(v == 32'hA, "R6 run bit cleared", v, 32'hA);
            repeat (10) @(negedge clk);
            rd(cofs(t), v); chk(v == 0, "R6 count stays zero", v, 0);
            wr(6'h20, W'(1 << t));
            repeat (10) @(negedge clk);
            chk(irq_o[t] == 1'b0, "R6 no second flag", W'(irq_o), 0);
        end

        // R7 / R8: write-one-to-clear, status layout
        wr(6'h08, 32'h3); wr(6'h10, 32'h3);
        repeat (3) @(negedge clk);
        rd(6'h20, v); chk(v == 32'h3, "R8 status both flags", v, 32'h3);
        chk(irq_o == 2'b11, "R9 irq equals flags", W'(irq_o), 3);
        wr(6'h20, 32'hFFFF_FFFC);
        rd(6'h20, v); chk(v == 32'h3, "R7 write zero no effect", v, 32'h3);
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk(v == 32'h2, "R7 clear bit0 only", v, 32'h2);
        wr(6'h20, 32'h2);
        rd(6'h20, v); chk(v == 32'h0, "R7 clear bit1", v, 32'h0);

        // R7: clear coinciding with expiry, reload zero fires every clock
        wr(6'h08, 32'h1);
        @(negedge clk);
        wr(6'h20, 32'h1);
        chk(irq_o[0] == 1'b1, "R7 expiry beats clear", W'(irq_o), 1);
        wr(6'h08, 32'h0);
        wr(6'h20, 32'h1);
        chk(irq_o[0] == 1'b0, "R7 cleared after stop", W'(irq_o), 0);

        // R8: unmapped offsets
        rd(6'h00, v); chk(v == 0, "R8 offset 0x00", v, 0);
        rd(6'h14, v); chk(v == 0, "R8 offset 0x14", v, 0);
        rd(6'h3C, v); chk(v == 0, "R8 offset 0x3C", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule